// File: doc/BRIEF.md
# Network Controller Gate-Array Register Bank

This block is the byte-wide register file of a network adapter's glue logic. It sits on a 16-byte host I/O window next to an Ethernet controller core. It holds the receive ring page bounds and a drain threshold. It also holds an adapter configuration byte, a control byte, a status byte, an interrupt/DMA channel select byte and a 20-bit vector pointer.

Two of the readable offsets return one-hot codes worked out from board straps: one for the I/O base and one for the memory window base. The control register exposes the data-port enable and other mode bits to neighbouring blocks. Writing the control register with bit 0 set performs a soft reset of the bank and sends a one-cycle reset to the controller core.

The bank also screens the select register so that it never holds more than one interrupt line or more than one DMA channel. The interrupt request level follows the configuration register. The host uses this block by issuing single-cycle write strobes with an offset and a data byte. It reads any offset combinationally.

Top module: `nic_ga_regs`

## Requirements
- R1: While `rst` is high and after it falls, every register reads 0x00 except control, which reads 0x0A; `irq_req`, `core_rst` and `isr_rst_set` are 0.
- R2: Offsets 0x0 (ring start page), 0x1 (ring stop page) and 0x2 (drain threshold) read back the last written byte from the cycle after the write strobe.
- R3: A control write (offset 0x6) with data bit 0 set causes three things at that clock edge. Control becomes 0x0B whatever the other data bits are. Every other register of the bank is cleared to 0x00. `core_rst` and `isr_rst_set` are high for exactly the next cycle. `irq_req` keeps its level.
- R4: A control write with bit 0 clear that changes control bit 7 sets status bits 7 and 3 to the new bit 7 value and clears status bit 4. A control write that keeps bit 7 leaves status unchanged.
- R5: Offset 0x3 reads a one-hot code of `io_strap`: 0x2E0→0x01, 0x2A0→0x02, 0x280→0x04, 0x250→0x08, 0x350→0x10, 0x330→0x20, 0x310→0x40, 0x300→0x80. Any other strap value reads 0x80.
- R6: Offset 0x4 reads a one-hot code of `mem_strap`: 0xC8000→0x10, 0xCC000→0x20, 0xD8000→0x40, 0xDC000→0x80. Any other strap value reads 0x00.
- R7: A write to the select register (offset 0x8) treats its two nibbles separately. The upper nibble (interrupt line) is stored only if it is 0x0, 0x1, 0x2, 0x4 or 0x8. The lower nibble (DMA channel) is stored only if it is 0x0, 0x1, 0x2 or 0x4. A rejected nibble keeps its old value.
- R8: A write to offset 0x5 stores the byte as the configuration register. From the next cycle, `irq_req` is 1 if data bit 7 was 0 and 0 if it was 1.
- R9: Offset 0xB holds vector pointer bits 19:12 and offset 0xC holds bits 11:4. Offset 0xD writes bits 3:0 from data bits 7:4 and reads them in bits 7:4 with zeros below. Each write leaves the other pointer bits untouched, and `vptr_o` carries the full pointer.
- R10: Status (offset 0x7) is read-only. Offsets 0x9, 0xA, 0xE and 0xF read 0x00, and writes to them change no register.
- R11: `ctrl_o`, `cfg_o` and `sel_o` equal the control, configuration and select registers. A register keeps its value in every cycle without a write to it or a soft reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 4 | Register offset for reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read data for `addr` |
| io_strap | input | 12 | Strapped I/O base address |
| mem_strap | input | 20 | Strapped memory window base address |
| core_rst | output | 1 | One-cycle reset pulse to the controller core |
| isr_rst_set | output | 1 | One-cycle request to set the core's reset status flag |
| irq_req | output | 1 | Interrupt request level |
| ctrl_o | output | 8 | Control register (mode bits, bit 7 data-port enable) |
| cfg_o | output | 8 | Configuration register |
| sel_o | output | 8 | Interrupt/DMA select register |
| vptr_o | output | 20 | Vector pointer |

## Verification
Every register write lands at the clock edge that samples the strobe, so register reads, `irq_req`, `ctrl_o` and the status edits are due one cycle after the strobe. The reset pulses are due in that same cycle and are gone one cycle later. Strap codes are combinational and are due as soon as the strap or the offset changes. The bench drives every input on the falling edge and samples one nanosecond later. Each write's effect is therefore checked in the half cycle right after the edge that took it. The reset pulse is checked at that point and again one full cycle later to confirm it lasts a single cycle.

// File: rtl/nic_ga_pkg.sv
package nic_ga_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int VPTR_W  = 20;
    localparam int IO_W    = 12;
    localparam int MEM_W   = 20;
    localparam int NIB_W   = DATA_W / 2;
    localparam int IO_N    = 8;
    localparam int MEM_N   = 4;

    localparam logic [DATA_W-1:0] CTRL_RST_VAL  = 8'h0A;
    localparam logic [DATA_W-1:0] CTRL_SOFT_VAL = 8'h0B;

    typedef enum logic [ADDR_W-1:0] {
        OFF_PSTART = 4'h0,
        OFF_PSTOP  = 4'h1,
        OFF_DRAIN  = 4'h2,
        OFF_IOCODE = 4'h3,
        OFF_MEMCODE= 4'h4,
        OFF_CFG    = 4'h5,
        OFF_CTRL   = 4'h6,
        OFF_STAT   = 4'h7,
        OFF_SEL    = 4'h8,
        OFF_VHI    = 4'hB,
        OFF_VMID   = 4'hC,
        OFF_VLO    = 4'hD
    } ga_off_e;

    // Index i of each table gives code bit i.
    localparam logic [IO_N-1:0][IO_W-1:0] IO_BASE_TAB = {
        12'h300, 12'h310, 12'h330, 12'h350,
        12'h250, 12'h280, 12'h2A0, 12'h2E0
    };
    localparam logic [MEM_N-1:0][MEM_W-1:0] MEM_BASE_TAB = {
        20'hDC000, 20'hD8000, 20'hCC000, 20'hC8000
    };

    typedef struct packed {
        logic [DATA_W-1:0] pstart;
        logic [DATA_W-1:0] pstop;
        logic [DATA_W-1:0] drain;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] sel;
        logic [VPTR_W-1:0] vptr;
    } ga_regs_t;

    function automatic logic nib_ok_irq(input logic [NIB_W-1:0] n);
        return ($countones(n) <= 1);
    endfunction

    function automatic logic nib_ok_dma(input logic [NIB_W-1:0] n);
        return ($countones(n) <= 1) && !n[NIB_W-1];
    endfunction

endpackage

// File: rtl/ga_strap_enc.sv
module ga_strap_enc
    import nic_ga_pkg::*;
(
    input  logic [IO_W-1:0]   io_strap,
    input  logic [MEM_W-1:0]  mem_strap,
    output logic [DATA_W-1:0] io_code,
    output logic [DATA_W-1:0] mem_code
);
    logic [IO_N-1:0]  io_hit;
    logic [MEM_N-1:0] mem_hit;

    for (genvar i = 0; i < IO_N; i++) begin : g_io
        assign io_hit[i] = (io_strap == IO_BASE_TAB[i]);
    end

    for (genvar j = 0; j < MEM_N; j++) begin : g_mem
        assign mem_hit[j] = (mem_strap == MEM_BASE_TAB[j]);
    end

    // An unlisted I/O base falls back to the top code.
    assign io_code  = (|io_hit) ? io_hit : 8'h80;
    assign mem_code = {mem_hit, {(DATA_W-MEM_N){1'b0}}};

endmodule

// File: rtl/ga_sel_filter.sv
module ga_sel_filter
    import nic_ga_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] nxt
);
    logic [NIB_W-1:0] hi_w, lo_w;

    assign hi_w = wdata[DATA_W-1:NIB_W];
    assign lo_w = wdata[NIB_W-1:0];

    assign nxt[DATA_W-1:NIB_W] = nib_ok_irq(hi_w) ? hi_w : cur[DATA_W-1:NIB_W];
    assign nxt[NIB_W-1:0]      = nib_ok_dma(lo_w) ? lo_w : cur[NIB_W-1:0];

endmodule

// File: rtl/ga_ctrl_unit.sv
module ga_ctrl_unit
    import nic_ga_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              soft_req,
    output logic              rst_pulse,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] status_q
);
    localparam int EN_BIT = DATA_W - 1;

    assign soft_req = ctrl_we && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RST_VAL;
            status_q  <= '0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= soft_req;
            if (soft_req) begin
                ctrl_q   <= CTRL_SOFT_VAL;
                status_q <= '0;
            end else if (ctrl_we) begin
                if (wdata[EN_BIT] != ctrl_q[EN_BIT]) begin
                    status_q[7] <= wdata[EN_BIT];
                    status_q[3] <= wdata[EN_BIT];
                    status_q[4] <= 1'b0;
                end
                ctrl_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/nic_ga_regs.sv
module nic_ga_regs
    import nic_ga_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [11:0]       io_strap,
    input  logic [19:0]       mem_strap,
    output logic              core_rst,
    output logic              isr_rst_set,
    output logic              irq_req,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        cfg_o,
    output logic [7:0]        sel_o,
    output logic [19:0]       vptr_o
);
    localparam int VLO_W = VPTR_W - 2 * DATA_W;

    ga_regs_t          regs_q;
    logic [DATA_W-1:0] ctrl_q, status_q;
    logic [DATA_W-1:0] io_code, mem_code, sel_nxt;
    logic              soft_req, rst_pulse;
    logic              irq_q;

    ga_strap_enc u_strap (
        .io_strap (io_strap),
        .mem_strap(mem_strap),
        .io_code  (io_code),
        .mem_code (mem_code)
    );

    ga_sel_filter u_sel (
        .cur  (regs_q.sel),
        .wdata(wr_data),
        .nxt  (sel_nxt)
    );

    ga_ctrl_unit u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (wr_en && (addr == OFF_CTRL)),
        .wdata    (wr_data),
        .soft_req (soft_req),
        .rst_pulse(rst_pulse),
        .ctrl_q   (ctrl_q),
        .status_q (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_req) begin
            regs_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFF_PSTART: regs_q.pstart <= wr_data;
                OFF_PSTOP:  regs_q.pstop  <= wr_data;
                OFF_DRAIN:  regs_q.drain  <= wr_data;
                OFF_CFG:    regs_q.cfg    <= wr_data;
                OFF_SEL:    regs_q.sel    <= sel_nxt;
                OFF_VHI:    regs_q.vptr[VPTR_W-1 -: DATA_W] <= wr_data;
                OFF_VMID:   regs_q.vptr[VLO_W +: DATA_W]    <= wr_data;
                OFF_VLO:    regs_q.vptr[VLO_W-1:0]          <= wr_data[DATA_W-1 -: VLO_W];
                default: ;
            endcase
        end
    end

    // Interrupt level survives a soft reset; only a configuration write moves it.
    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (wr_en && (addr == OFF_CFG))
            irq_q <= ~wr_data[DATA_W-1];
    end

    always_comb begin
        unique case (addr)
            OFF_PSTART:  rd_data = regs_q.pstart;
            OFF_PSTOP:   rd_data = regs_q.pstop;
            OFF_DRAIN:   rd_data = regs_q.drain;
            OFF_IOCODE:  rd_data = io_code;
            OFF_MEMCODE: rd_data = mem_code;
            OFF_CFG:     rd_data = regs_q.cfg;
            OFF_CTRL:    rd_data = ctrl_q;
            OFF_STAT:    rd_data = status_q;
            OFF_SEL:     rd_data = regs_q.sel;
            OFF_VHI:     rd_data = regs_q.vptr[VPTR_W-1 -: DATA_W];
            OFF_VMID:    rd_data = regs_q.vptr[VLO_W +: DATA_W];
            OFF_VLO:     rd_data = {regs_q.vptr[VLO_W-1:0], {(DATA_W-VLO_W){1'b0}}};
            default:     rd_data = '0;
        endcase
    end

    assign core_rst    = rst_pulse;
    assign isr_rst_set = rst_pulse;
    assign irq_req     = irq_q;
    assign ctrl_o      = ctrl_q;
    assign cfg_o       = regs_q.cfg;
    assign sel_o       = regs_q.sel;
    assign vptr_o      = regs_q.vptr;

endmodule

// File: rtl/ga_regs_chk.sv
module ga_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [3:0] addr,
    input logic [7:0] wr_data,
    input logic       core_rst,
    input logic       irq_req,
    input logic [7:0] ctrl_o,
    input logic [7:0] sel_o,
    input logic [7:0] status_q
);
    AST_RST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> !core_rst) else $error("reset pulse too long"); // R3

    AST_RST_PULSE_CTRL: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (ctrl_o == 8'h0B)) else $error("control not 0x0B on pulse"); // R3

    AST_STATUS_TRACKS_EN: assert property (@(posedge clk) disable iff (rst)
        (status_q[7] == ctrl_o[7]) && (status_q[3] == ctrl_o[7])) else $error("status/enable mismatch"); // R4

    AST_SEL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o[7:4]) && $onehot0(sel_o[3:0]) && !sel_o[3]) else $error("multi-hot select"); // R7

    AST_IRQ_FROM_CFG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'h5) |=> (irq_req == !$past(wr_data[7]))) else $error("irq level wrong"); // R8

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 4'h6) |=> $stable(ctrl_o)) else $error("control moved without write"); // R11
endmodule

bind nic_ga_regs ga_regs_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .core_rst(core_rst),
    .irq_req (irq_req),
    .ctrl_o  (ctrl_o),
    .sel_o   (sel_o),
    .status_q(status_q)
);

// File: tb/tb_nic_ga_regs.sv
`timescale 1ns/100ps
module tb_nic_ga_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [11:0] io_strap = 12'h300;
    logic [19:0] mem_strap = 20'hCC000;
    logic        core_rst, isr_rst_set, irq_req;
    logic [7:0]  ctrl_o, cfg_o, sel_o;
    logic [19:0] vptr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nic_ga_regs dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .io_strap(io_strap), .mem_strap(mem_strap),
        .core_rst(core_rst), .isr_rst_set(isr_rst_set), .irq_req(irq_req),
        .ctrl_o(ctrl_o), .cfg_o(cfg_o), .sel_o(sel_o), .vptr_o(vptr_o)
    );

    // {waddr[31:28], wdata[27:20], raddr[19:16], expect[15:8], req[7:0]}
    localparam int NV = 21;
    localparam logic [31:0] VEC [NV] = '{
        {4'h0, 8'h55, 4'h0, 8'h55, 8'd2},   // R2
        {4'h1, 8'hAA, 4'h1, 8'hAA, 8'd2},   // R2
        {4'h2, 8'h0F, 4'h2, 8'h0F, 8'd2},   // R2
        {4'h0, 8'hC3, 4'h0, 8'hC3, 8'd2},   // R2
        {4'h8, 8'h21, 4'h8, 8'h21, 8'd7},   // R7 both accepted
        {4'h8, 8'h34, 4'h8, 8'h24, 8'd7},   // R7 upper rejected
        {4'h8, 8'h88, 4'h8, 8'h84, 8'd7},   // R7 lower 8 rejected
        {4'h8, 8'h03, 4'h8, 8'h04, 8'd7},   // R7 lower multi-hot rejected
        {4'h8, 8'hF0, 4'h8, 8'h00, 8'd7},   // R7 upper multi-hot rejected
        {4'hB, 8'hA5, 4'hB, 8'hA5, 8'd9},   // R9
        {4'hC, 8'h3C, 4'hC, 8'h3C, 8'd9},   // R9
        {4'hD, 8'h7F, 4'hD, 8'h70, 8'd9},   // R9 low nibble dropped
        {4'hB, 8'h11, 4'hC, 8'h3C, 8'd9},   // R9 middle untouched
        {4'h6, 8'h8A, 4'h7, 8'h88, 8'd4},   // R4 enable rises
        {4'h6, 8'h82, 4'h7, 8'h88, 8'd4},   // R4 no toggle
        {4'h6, 8'h02, 4'h7, 8'h00, 8'd4},   // R4 enable falls
        {4'h7, 8'hFF, 4'h7, 8'h00, 8'd10},  // R10 status read-only
        {4'h6, 8'h02, 4'h6, 8'h02, 8'd11},  // R11
        {4'h5, 8'h09, 4'h5, 8'h09, 8'd8},   // R8
        {4'h9, 8'h77, 4'h9, 8'h00, 8'd10},  // R10
        {4'hE, 8'h12, 4'hE, 8'h00, 8'd10}   // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [7:0] v;
        logic [11:0] io_vals [8] = '{12'h2E0, 12'h2A0, 12'h280, 12'h250,
                                     12'h350, 12'h330, 12'h310, 12'h300};
        logic [19:0] mem_vals [4] = '{20'hC8000, 20'hCC000, 20'hD8000, 20'hDC000};

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            if (a == 3 || a == 4) continue;
            rd(a[3:0], v);
            check("R1", v, (a == 6) ? 8'h0A : 8'h00);
        end
        check("R1", {core_rst, isr_rst_set, irq_req}, 3'b000);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][31:28], VEC[i][27:20]);
            rd(VEC[i][19:16], v);
            check($sformatf("R%0d", VEC[i][7:0]), v, VEC[i][15:8]);
        end
        check("R11", {ctrl_o, cfg_o, sel_o}, {8'h02, 8'h09, 8'h00});
        check("R9", vptr_o, 20'h113C7);

        // R5: I/O strap codes
        for (int i = 0; i < 8; i++) begin
            io_strap = io_vals[i];
            rd(4'h3, v);
            check("R5", v, 8'h01 << i);
        end
        io_strap = 12'h123;
        rd(4'h3, v);
        check("R5", v, 8'h80);

        // R6: memory strap codes
        for (int i = 0; i < 4; i++) begin
            mem_strap = mem_vals[i];
            rd(4'h4, v);
            check("R6", v, 8'h10 << i);
        end
        mem_strap = 20'hE0000;
        rd(4'h4, v);
        check("R6", v, 8'h00);

        // R8: interrupt level from configuration bit 7
        wr(4'h5, 8'h00);
        check("R8", irq_req, 1'b1);
        wr(4'h5, 8'h80);
        check("R8", irq_req, 1'b0);
        wr(4'h5, 8'h7F);
        check("R8", irq_req, 1'b1);

        // R3: soft reset
        wr(4'h0, 8'h5A);
        wr(4'h8, 8'h42);
        wr(4'hB, 8'hFE);
        wr(4'h6, 8'h80);
        wr(4'h6, 8'hF1);
        check("R3", {core_rst, isr_rst_set}, 2'b11);
        check("R3", ctrl_o, 8'h0B);
        check("R3", irq_req, 1'b1);
        @(negedge clk); #1;
        check("R3", {core_rst, isr_rst_set}, 2'b00);
        rd(4'h0, v); check("R3", v, 8'h00);
        rd(4'h7, v); check("R3", v, 8'h00);
        rd(4'h5, v); check("R3", v, 8'h00);
        check("R3", {sel_o, vptr_o}, 28'h0);

        // R1: hard reset restores 0x0A and drops irq
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R1", {ctrl_o, irq_req}, {8'h0A, 1'b0});

        summary();
    end
endmodule